// File: doc/BRIEF.md
# DS3 Far-End Alarm Code Transmitter

This block sends a far-end alarm and control code to the remote terminal, one bit per outbound DS3 frame. A host writes a 6-bit alarm code into a register, then uses a control register to turn the transmitter on and to launch a message. The block wraps the code in a 16-bit codeword. Each time the framer pulses its per-frame FEAC-slot strobe, the block moves one bit of that codeword onto a registered serial output.

The block counts complete passes of the codeword. When the tenth pass ends it latches an interrupt status flag. A mask bit decides whether that flag drives the interrupt pin. The far-end receiver only accepts a code after it has seen the same codeword eight times, so ten passes leave some margin.

After the tenth pass the codeword keeps repeating until the host starts a new message or turns the transmitter off. While the transmitter is off, every slot carries a 1, which the far end reads as idle. Turning the transmitter on without a launch command resends the code captured by the most recent launch. A host that wants a new code must therefore enable and launch in a single write.

Top module: `feac_tx_top`

## Requirements
- R1: After reset, feac_bit is 1, irq is 0, and both registers read as 0.
- R2: Register map, with data CODE_W=6 bits wide. Address 0 holds the code in bits 5:0. Address 1 is control: bit 0 is the interrupt mask (1 = enabled), bit 1 is transmit enable, and bit 2 is launch, which is write-only and reads as 0. Bit 3 reads the interrupt status. Read data appears on host_rdata one cycle after host_rd.
- R3: Within a pass, slot index 0 through 15 carries, in order: 0, then code bits c0 through c5 (least significant first), then 0, then eight 1s.
- R4: feac_bit changes only on a clock edge where slot_stb is high. It then holds until the next strobe.
- R5: A control write with both launch and enable set does three things: it copies the code register into the active code, clears the pass counter, and makes the next strobe after the write cycle send slot 0. This applies even in the middle of a pass.
- R6: A control write that raises enable from 0 to 1 without launch restarts at slot 0 with the active code from the last launch (0 after reset). It also clears the pass counter.
- R7: A launch written while enable is written as 0 has no effect on the active code.
- R8: While enable is 0, every strobe puts a 1 on feac_bit.
- R9: When the tenth pass ends, the interrupt status sets. irq equals the status ANDed with the mask.
- R10: After the tenth pass the codeword keeps repeating. The pass count saturates at 10, so each launch raises the status at most once.
- R11: Reading address 1 returns the status as it was before the read, then clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the host port and the slot strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 1 | Register select: 0 = code, 1 = control/status |
| host_wdata | input | 6 | Write data |
| host_rdata | output | 6 | Registered read data |
| slot_stb | input | 1 | One-cycle pulse marking one FEAC bit slot of a frame |
| feac_bit | output | 1 | Serial FEAC bit for the current frame |
| irq | output | 1 | Masked pass-complete interrupt |

## Verification
The assertions assume three things about the inputs. slot_stb is a single-cycle pulse, synchronous to clk. Host accesses never coincide with a strobe. A launch never lands in the same cycle as a strobe. The bench respects all three: each strobe is a one-cycle pulse surrounded by idle cycles, and every register write or read sits in its own cycle between strobes. With those limits, slot order, idle ones, output holding and saturation are all checked against a model the bench computes from the codeword layout.

// File: rtl/feac_pkg.sv
package feac_pkg;
  localparam int unsigned CTL_IE_BIT    = 0;
  localparam int unsigned CTL_EN_BIT    = 1;
  localparam int unsigned CTL_GO_BIT    = 2;
  localparam int unsigned CTL_STAT_BIT  = 3;

  typedef enum logic {
    ADDR_CODE = 1'b0,
    ADDR_CTRL = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic en;
    logic ie;
  } ctrl_t;
endpackage

// File: rtl/feac_host_regs.sv
module feac_host_regs
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              rd,
  input  logic              addr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              pass_hit,
  output logic [CODE_W-1:0] rdata,
  output logic [CODE_W-1:0] code_q,
  output ctrl_t             ctrl_q,
  output logic              stat_q,
  output logic              launch_new,
  output logic              restart
);
  logic [CODE_W-1:0] code_d;
  ctrl_t             ctrl_d;
  logic              stat_d;
  logic [CODE_W-1:0] rdata_d;
  logic              ctl_wr;
  logic              stat_rd;

  always_comb begin
    ctl_wr     = wr && (reg_sel_e'(addr) == ADDR_CTRL);
    stat_rd    = rd && (reg_sel_e'(addr) == ADDR_CTRL);
    code_d     = code_q;
    ctrl_d     = ctrl_q;
    launch_new = 1'b0;
    restart    = 1'b0;
    if (wr && (reg_sel_e'(addr) == ADDR_CODE)) begin
      code_d = wdata;
    end
    if (ctl_wr) begin
      ctrl_d.ie  = wdata[CTL_IE_BIT];
      ctrl_d.en  = wdata[CTL_EN_BIT];
      launch_new = wdata[CTL_GO_BIT] && wdata[CTL_EN_BIT];
      restart    = launch_new || (wdata[CTL_EN_BIT] && !ctrl_q.en);
    end
  end

  always_comb begin
    stat_d = stat_q;
    if (pass_hit) begin
      stat_d = 1'b1;
    end else if (stat_rd) begin
      stat_d = 1'b0;
    end
  end

  always_comb begin
    rdata_d = '0;
    if (reg_sel_e'(addr) == ADDR_CODE) begin
      rdata_d = code_q;
    end else begin
      rdata_d[CTL_IE_BIT]   = ctrl_q.ie;
      rdata_d[CTL_EN_BIT]   = ctrl_q.en;
      rdata_d[CTL_STAT_BIT] = stat_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ctrl_q <= '0;
      stat_q <= 1'b0;
      rdata  <= '0;
    end else begin
      code_q <= code_d;
      ctrl_q <= ctrl_d;
      stat_q <= stat_d;
      if (rd) begin
        rdata <= rdata_d;
      end
    end
  end
endmodule

// File: rtl/feac_serializer.sv
module feac_serializer #(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned ONES_W = 8,
  localparam int unsigned LEN   = CODE_W + ONES_W + 2,
  localparam int unsigned IDX_W = $clog2(LEN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic              en,
  input  logic              restart,
  input  logic              ld,
  input  logic [CODE_W-1:0] ld_code,
  output logic [IDX_W-1:0]  idx_q,
  output logic              wrap,
  output logic              feac_q
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(LEN - 1);

  logic [CODE_W-1:0] act_q;
  logic [CODE_W-1:0] act_d;
  logic [LEN-1:0]    word;
  logic [IDX_W-1:0]  idx_d;
  logic              feac_d;
  logic              step;

  always_comb begin
    word = {{ONES_W{1'b1}}, 1'b0, act_q, 1'b0};
  end

  always_comb begin
    step   = stb && en && !restart;
    wrap   = step && (idx_q == LAST);
    act_d  = ld ? ld_code : act_q;
    idx_d  = idx_q;
    if (restart) begin
      idx_d = '0;
    end else if (step) begin
      idx_d = (idx_q == LAST) ? '0 : idx_q + 1'b1;
    end
    feac_d = feac_q;
    if (stb) begin
      feac_d = en ? word[idx_q] : 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      idx_q  <= '0;
      feac_q <= 1'b1;
    end else begin
      act_q  <= act_d;
      idx_q  <= idx_d;
      feac_q <= feac_d;
    end
  end
endmodule

// File: rtl/feac_pass_counter.sv
module feac_pass_counter #(
  parameter int unsigned TARGET = 10,
  localparam int unsigned CNT_W = $clog2(TARGET + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             adv,
  output logic [CNT_W-1:0] cnt_q,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_d;
  logic             below;

  always_comb begin
    below = (cnt_q < CNT_W'(TARGET));
    hit   = adv && (cnt_q == CNT_W'(TARGET - 1));
    cnt_d = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (adv && below) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/feac_tx_top.sv
module feac_tx_top
  import feac_pkg::*;
#(
  parameter int unsigned CODE_W = 6,
  parameter int unsigned ONES_W = 8,
  parameter int unsigned TARGET = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic              host_addr,
  input  logic [CODE_W-1:0] host_wdata,
  output logic [CODE_W-1:0] host_rdata,
  input  logic              slot_stb,
  output logic              feac_bit,
  output logic              irq
);
  localparam int unsigned LEN   = CODE_W + ONES_W + 2;
  localparam int unsigned IDX_W = $clog2(LEN);
  localparam int unsigned CNT_W = $clog2(TARGET + 1);

  logic [1:0]        rst_sync;
  logic              rst_int_n;
  logic [CODE_W-1:0] code_q;
  ctrl_t             ctrl_q;
  logic              stat_q;
  logic              launch_new;
  logic              restart;
  logic              wrap;
  logic              pass_hit;
  logic [IDX_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  rep_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync[1];

  feac_host_regs #(.CODE_W(CODE_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr        (host_wr),
    .rd        (host_rd),
    .addr      (host_addr),
    .wdata     (host_wdata),
    .pass_hit  (pass_hit),
    .rdata     (host_rdata),
    .code_q    (code_q),
    .ctrl_q    (ctrl_q),
    .stat_q    (stat_q),
    .launch_new(launch_new),
    .restart   (restart)
  );

  feac_serializer #(.CODE_W(CODE_W), .ONES_W(ONES_W)) u_ser (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .stb    (slot_stb),
    .en     (ctrl_q.en),
    .restart(restart),
    .ld     (launch_new),
    .ld_code(code_q),
    .idx_q  (bit_idx),
    .wrap   (wrap),
    .feac_q (feac_bit)
  );

  feac_pass_counter #(.TARGET(TARGET)) u_cnt (
    .clk  (clk),
    .rst_n(rst_int_n),
    .clr  (restart),
    .adv  (wrap),
    .cnt_q(rep_cnt),
    .hit  (pass_hit)
  );

  assign irq = stat_q && ctrl_q.ie;
endmodule

// File: rtl/feac_tx_checker.sv
module feac_tx_checker #(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned CNT_W  = 4,
  parameter int unsigned TARGET = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             slot_stb,
  input logic             feac_bit,
  input logic             irq,
  input logic             en,
  input logic             ie,
  input logic             stat,
  input logic             restart,
  input logic [IDX_W-1:0] idx,
  input logic [CNT_W-1:0] cnt
);
  // R4: output moves only on a slot strobe
  p_hold_between_slots_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_stb |=> $stable(feac_bit));

  // R8: disabled transmitter sends idle ones
  p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && !en) |=> feac_bit);

  // R3: first slot of each pass carries a zero
  p_pass_starts_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_stb && en && !restart && (idx == '0)) |=> !feac_bit);

  // R9: interrupt pin only with mask set
  p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && stat));

  // R10: pass count never exceeds the target
  p_cnt_saturates_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(TARGET));

  // R9: status rises only when the tenth pass completes
  p_stat_on_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat) |-> (cnt == CNT_W'(TARGET)));
endmodule

bind feac_tx_top feac_tx_checker #(
  .IDX_W (IDX_W),
  .CNT_W (CNT_W),
  .TARGET(TARGET)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .slot_stb(slot_stb),
  .feac_bit(feac_bit),
  .irq     (irq),
  .en      (ctrl_q.en),
  .ie      (ctrl_q.ie),
  .stat    (stat_q),
  .restart (restart),
  .idx     (bit_idx),
  .cnt     (rep_cnt)
);

// File: tb/sim_feac_tx_top.sv
`timescale 1ns/1ps
module sim_feac_tx_top;
  logic       clk;
  logic       rst_n;
  logic       host_wr;
  logic       host_rd;
  logic       host_addr;
  logic [5:0] host_wdata;
  logic [5:0] host_rdata;
  logic       slot_stb;
  logic       feac_bit;
  logic       irq;

  int n_run;
  int n_fail;
  bit finished;
  bit mon_on;
  bit stb_seen;
  logic last_bit;

  logic  exp_q[$];
  string tag_q[$];

  // bench model, built from the requirements
  bit       m_en, m_ie, m_stat;
  bit [5:0] m_code, m_act;
  int       m_idx, m_cnt;

  feac_tx_top u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .slot_stb(slot_stb), .feac_bit(feac_bit), .irq(irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic word_bit(input bit [5:0] code, input int i);
    if (i == 0 || i == 7) return 1'b0;
    if (i >= 1 && i <= 6) return code[i-1];
    return 1'b1;
  endfunction

  always @(posedge clk) stb_seen <= slot_stb;

  // monitor: pops expected slot values, checks holding between slots
  always @(negedge clk) begin
    if (mon_on) begin
      if (stb_seen) begin
        if (exp_q.size() == 0) begin
          check("R4 unexpected slot", 1, 0);
        end else begin
          logic  e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(t, int'(feac_bit), int'(e));
          last_bit = e;
        end
      end else begin
        check("R4 hold", int'(feac_bit), int'(last_bit));
      end
    end
  end

  task automatic slot(input string tag);
    logic e;
    @(negedge clk);
    slot_stb = 1'b1;
    if (m_en) begin
      e = word_bit(m_act, m_idx);
      if (m_idx == 15) begin
        m_idx = 0;
        if (m_cnt < 10) begin
          m_cnt++;
          if (m_cnt == 10) m_stat = 1'b1;
        end
      end else begin
        m_idx++;
      end
    end else begin
      e = 1'b1;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    slot_stb = 1'b0;
    @(negedge clk);
  endtask

  task automatic slots(input int n, input string tag);
    for (int i = 0; i < n; i++) slot(tag);
  endtask

  task automatic wr(input bit a, input bit [5:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
    if (!a) begin
      m_code = d;
    end else begin
      if (d[2] && d[1]) begin
        m_act = m_code; m_idx = 0; m_cnt = 0;
      end else if (d[1] && !m_en) begin
        m_idx = 0; m_cnt = 0;
      end
      m_en = d[1];
      m_ie = d[0];
    end
  endtask

  task automatic rd(input bit a, input string tag);
    int e;
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    if (!a) e = int'(m_code);
    else begin
      e = (int'(m_stat) << 3) | (int'(m_en) << 1) | int'(m_ie);
      m_stat = 1'b0;
    end
    check(tag, int'(host_rdata), e);
  endtask

  task automatic chk_irq(input string tag);
    check(tag, int'(irq), int'(m_stat && m_ie));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; host_wr = 1'b0; host_rd = 1'b0; host_addr = 1'b0;
    host_wdata = '0; slot_stb = 1'b0; last_bit = 1'b1; mon_on = 1'b0;
    m_en = 0; m_ie = 0; m_stat = 0; m_code = 0; m_act = 0; m_idx = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    check("R1 feac_bit", int'(feac_bit), 1);
    check("R1 irq", int'(irq), 0);
    rd(1'b0, "R1 code reg");
    rd(1'b1, "R1 ctrl reg");
    mon_on = 1'b1;

    // R8 idle while disabled
    slots(3, "R8 idle");

    // R7 launch while disabled is ignored (bit0 ie, bit2 launch)
    wr(1'b0, 6'h15);
    wr(1'b1, 6'b000101);
    rd(1'b1, "R2 ctrl readback, launch reads 0");
    slots(2, "R7 still idle");

    // R6 enable without launch: active code still reset value 0
    wr(1'b1, 6'b000011);
    slots(16, "R6 old code after enable");
    wr(1'b1, 6'b000001);
    slots(2, "R8 idle after disable");

    // R5 launch with 0x15, then R3 order, R9 after tenth pass
    wr(1'b1, 6'b000111);
    slots(9 * 16, "R3 codeword 0x15");
    chk_irq("R9 no irq after nine passes");
    slots(16, "R3 tenth pass");
    check("R9 irq after ten passes", int'(irq), 1);
    chk_irq("R9 irq model");
    rd(1'b1, "R11 status read");
    check("R11 irq cleared by read", int'(irq), 0);
    rd(1'b1, "R11 status after clear");

    // R10 keeps repeating, no second interrupt
    slots(48, "R10 repeat after tenth");
    chk_irq("R10 no second irq");
    rd(1'b1, "R10 status stays clear");

    // R5 mid-pass launch with new code, interrupt masked
    slots(5, "R3 partial pass");
    wr(1'b0, 6'h2A);
    rd(1'b0, "R2 code readback");
    wr(1'b1, 6'b000110);
    slots(10 * 16, "R5 restart at slot 0 with 0x2A");
    check("R9 masked irq", int'(irq), 0);
    rd(1'b1, "R9 status set while masked");

    // R6 re-enable resends last launched code, not the register
    wr(1'b1, 6'b000000);
    wr(1'b0, 6'h3F);
    slots(2, "R8 idle");
    wr(1'b1, 6'b000010);
    slots(16, "R6 resend 0x2A");
    wr(1'b1, 6'b000110);
    slots(16, "R5 launch 0x3F");

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule